// File: doc/BRIEF.md
# Mesh Core-to-Router Bus Allocator

This block binds processor cores of a small two-dimensional grid to routers, building one bus per allocation request. A request names how many cores it needs. The block selects a router on a best-fit rule, then grows a connected group of free cores outward from that router's attach core. At every step it takes the highest-priority core on the current frontier. An owner table records, for every core, either the router that owns it or the unassigned marker.

The grid is split into equal rectangular tiles, one per router. With the default 4x4 grid and 2x2 routers, each router reaches the four cores of its own tile. Router `r` owns the tile at tile column `r % RT_X` and tile row `r / RT_X`. Its attach core is the tile's top-left core. Core `c` sits at column `c % GRID_W`, row `c / GRID_W`.

A release port frees every core of one router. A fault port marks a core as dead for good. A read port shows the owner table and the dead flags. Only one request is served at a time.

Top module: `mesh_bus_alloc`

## Requirements
- R1: The priority of a core is `GRID_W - d`, where `d` is its distance in cores to the nearest grid edge. In the default grid, edge cores have 4 and the four centre cores have 3. Each growth step takes the frontier core with the highest priority. On equal priority, the lowest core index wins.
- R2: A router is a candidate when its tile holds at least NP free cores, where a free core is unassigned and not dead. Among the candidates, the router with the fewest free cores is chosen. On equal counts, the lowest router index wins.
- R3: The frontier contains the free cores of the chosen tile that either are the attach core or are north, south, east or west of a live core already owned by that router. On a grant, exactly NP cores have been newly bound to the chosen router.
- R4: A `rd_owner` value of all ones (-1) means the core is unassigned. Any other value is the zero-extended owning router index. The read is combinational from `rd_core`, and each core has at most one owner. After reset every entry is -1 and no core is dead.
- R5: A request is accepted when `req_valid` is high while `busy` is low. `busy` is high from the cycle after acceptance up to and including the cycle of the grant or fail pulse, and low in the cycle after it. On success, `grant` pulses NP+1 cycles after acceptance, with `grant_rt` naming the router. `req_valid` is ignored while `busy` is high.
- R6: If NP is 0, or no router is a candidate, `fail` pulses one cycle after acceptance and the owner table is not changed.
- R7: If the frontier empties after k cores have been taken but before NP is reached, the k partial bindings are undone. `fail` then pulses k+3 cycles after acceptance, and the owner table is left as it was before the request.
- R8: A core reported on the fault port is never bound by a later request and is never counted as free. It does not connect the frontier to its neighbours, and it keeps whatever owner value it had. `rd_failed` reads as 1 for it.
- R9: A release of router r while not busy returns every live core owned by r to -1. Dead cores keep their value. The change is visible in the cycle after the release. A release while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Allocation request strobe |
| req_np | input | NPW | Number of cores needed |
| busy | output | 1 | A request is in progress |
| grant | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| grant_rt | output | RW | Router that received the bus |
| rel_valid | input | 1 | Release strobe |
| rel_rt | input | RW | Router whose cores are released |
| flt_valid | input | 1 | Core fault strobe |
| flt_core | input | CW | Index of the faulty core |
| rd_core | input | CW | Owner table read index |
| rd_owner | output | OW | Owner of `rd_core` (all ones = unassigned) |
| rd_failed | output | 1 | `rd_core` is dead |

## Verification
The hardest case to reach is a stall partway through growth followed by rollback. It needs a router whose free count passes the best-fit test while its free cores are not connected to its attach core. The stimulus builds this with the fault port: it kills the two tile neighbours of an attach core, so one isolated free core still counts toward the total. A second stall case kills a core that the router already owns and then releases the router, which leaves a dead core blocking the router's only path to its free cores. Release and request strobes are also applied during a grow, to show that the table is untouched.

// File: rtl/mba_pkg.sv
`timescale 1ns/1ps
package mba_pkg;

  typedef enum logic [2:0] {S_IDLE, S_GROW, S_ROLL, S_DONE, S_FAIL} mba_state_e;

  // ring priority: edge rings score highest
  function automatic int core_prio(int c, int w, int h);
    int x, y, ring;
    x = c % w;
    y = c / w;
    ring = x;
    if (y < ring) ring = y;
    if (w - 1 - x < ring) ring = w - 1 - x;
    if (h - 1 - y < ring) ring = h - 1 - y;
    return w - ring;
  endfunction

  // router whose tile holds core c
  function automatic int core_tile(int c, int w, int tw, int th, int rx);
    return ((c / w) / th) * rx + (c % w) / tw;
  endfunction

  // top-left core of router r's tile
  function automatic int tile_attach(int r, int w, int tw, int th, int rx);
    return ((r / rx) * th) * w + (r % rx) * tw;
  endfunction

endpackage

// File: rtl/mba_fit.sv
`timescale 1ns/1ps
module mba_fit import mba_pkg::*; #(
  parameter int N_CORES = 16,
  parameter int N_RT    = 4,
  parameter int GRID_W  = 4,
  parameter int TILE_W  = 2,
  parameter int TILE_H  = 2,
  parameter int RT_X    = 2,
  parameter int NPW     = 5,
  parameter int RW      = 2
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] free_mask,
  input  logic [NPW-1:0]     np,
  output logic               fit_ok,
  output logic [RW-1:0]      fit_rt
);

  logic [N_RT-1:0][NPW-1:0] cnt;
  logic [NPW-1:0]           best;

  always_comb begin
    for (int r = 0; r < N_RT; r++) begin
      cnt[r] = '0;
      for (int c = 0; c < N_CORES; c++)
        if (free_mask[c] && core_tile(c, GRID_W, TILE_W, TILE_H, RT_X) == r)
          cnt[r] = cnt[r] + NPW'(1);
    end
  end

  // best fit: fewest free cores that still cover np, lowest index on ties
  always_comb begin
    fit_ok = 1'b0;
    fit_rt = '0;
    best   = '0;
    for (int r = 0; r < N_RT; r++)
      if (np != '0 && cnt[r] >= np && (!fit_ok || cnt[r] < best)) begin
        fit_ok = 1'b1;
        fit_rt = RW'(r);
        best   = cnt[r];
      end
  end

  // R2
  fit_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fit_ok |-> (np != '0 && cnt[fit_rt] >= np));

endmodule

// File: rtl/mba_pick.sv
`timescale 1ns/1ps
module mba_pick import mba_pkg::*; #(
  parameter int N_CORES = 16,
  parameter int GRID_W  = 4,
  parameter int GRID_H  = 4,
  parameter int TILE_W  = 2,
  parameter int TILE_H  = 2,
  parameter int RT_X    = 2,
  parameter int RW      = 2,
  parameter int CW      = 4
)(
  input  logic [N_CORES-1:0] free_mask,
  input  logic [N_CORES-1:0] mine_mask,
  input  logic [RW-1:0]      cur,
  output logic               pick_ok,
  output logic [CW-1:0]      pick_idx
);

  logic [N_CORES-1:0] front;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    localparam int CX = c % GRID_W;
    localparam int CY = c / GRID_W;
    localparam int TL = core_tile(c, GRID_W, TILE_W, TILE_H, RT_X);
    localparam bit IS_ATT = (tile_attach(TL, GRID_W, TILE_W, TILE_H, RT_X) == c);
    logic adj_w, adj_e, adj_n, adj_s;
    if (CX > 0) begin : g_w
      assign adj_w = mine_mask[c-1];
    end else begin : g_nw
      assign adj_w = 1'b0;
    end
    if (CX < GRID_W - 1) begin : g_e
      assign adj_e = mine_mask[c+1];
    end else begin : g_ne
      assign adj_e = 1'b0;
    end
    if (CY > 0) begin : g_n
      assign adj_n = mine_mask[c-GRID_W];
    end else begin : g_nn
      assign adj_n = 1'b0;
    end
    if (CY < GRID_H - 1) begin : g_s
      assign adj_s = mine_mask[c+GRID_W];
    end else begin : g_ns
      assign adj_s = 1'b0;
    end
    assign front[c] = free_mask[c] && (int'(cur) == TL) &&
                      (adj_w || adj_e || adj_n || adj_s || IS_ATT);
  end

  // highest ring priority first, lowest index on ties
  always_comb begin
    int best;
    pick_ok  = 1'b0;
    pick_idx = '0;
    best     = 0;
    for (int c = 0; c < N_CORES; c++)
      if (front[c] && (!pick_ok || core_prio(c, GRID_W, GRID_H) > best)) begin
        pick_ok  = 1'b1;
        pick_idx = CW'(c);
        best     = core_prio(c, GRID_W, GRID_H);
      end
  end

endmodule

// File: rtl/mesh_bus_alloc.sv
`timescale 1ns/1ps
module mesh_bus_alloc import mba_pkg::*; #(
  parameter int GRID_W = 4,
  parameter int GRID_H = 4,
  parameter int RT_X   = 2,
  parameter int RT_Y   = 2,
  localparam int N_CORES = GRID_W * GRID_H,
  localparam int N_RT    = RT_X * RT_Y,
  localparam int TILE_W  = GRID_W / RT_X,
  localparam int TILE_H  = GRID_H / RT_Y,
  localparam int CW      = $clog2(N_CORES),
  localparam int RW      = (N_RT > 1) ? $clog2(N_RT) : 1,
  localparam int OW      = RW + 1,
  localparam int NPW     = $clog2(N_CORES + 1)
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [NPW-1:0] req_np,
  output logic           busy,
  output logic           grant,
  output logic           fail,
  output logic [RW-1:0]  grant_rt,
  input  logic           rel_valid,
  input  logic [RW-1:0]  rel_rt,
  input  logic           flt_valid,
  input  logic [CW-1:0]  flt_core,
  input  logic [CW-1:0]  rd_core,
  output logic [OW-1:0]  rd_owner,
  output logic           rd_failed
);

  localparam logic [OW-1:0] UNASG = '1;

  mba_state_e                st_q;
  logic [RW-1:0]             cur_q;
  logic [NPW-1:0]            need_q, got_q;
  logic [N_CORES-1:0]        new_q, dead_q;
  logic [N_CORES-1:0][OW-1:0] own_q;
  logic [N_CORES-1:0]        free_mask, mine_mask;

  logic          fit_ok, pick_ok;
  logic [RW-1:0] fit_rt;
  logic [CW-1:0] pick_idx;

  // named events for the checks
  logic take_evt, roll_evt, rel_evt;
  assign take_evt = (st_q == S_GROW) && pick_ok;
  assign roll_evt = (st_q == S_ROLL);
  assign rel_evt  = rel_valid && (st_q == S_IDLE);

  always_comb begin
    for (int c = 0; c < N_CORES; c++) begin
      free_mask[c] = (own_q[c] == UNASG) && !dead_q[c];
      mine_mask[c] = (own_q[c] == {1'b0, cur_q}) && !dead_q[c];
    end
  end

  mba_fit #(
    .N_CORES(N_CORES), .N_RT(N_RT), .GRID_W(GRID_W), .TILE_W(TILE_W),
    .TILE_H(TILE_H), .RT_X(RT_X), .NPW(NPW), .RW(RW)
  ) u_fit (
    .clk(clk), .rst_n(rst_n), .free_mask(free_mask), .np(req_np),
    .fit_ok(fit_ok), .fit_rt(fit_rt)
  );

  mba_pick #(
    .N_CORES(N_CORES), .GRID_W(GRID_W), .GRID_H(GRID_H), .TILE_W(TILE_W),
    .TILE_H(TILE_H), .RT_X(RT_X), .RW(RW), .CW(CW)
  ) u_pick (
    .free_mask(free_mask), .mine_mask(mine_mask), .cur(cur_q),
    .pick_ok(pick_ok), .pick_idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      need_q <= '0;
      got_q  <= '0;
      new_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          new_q <= '0;
          got_q <= '0;
          if (fit_ok) begin
            st_q   <= S_GROW;
            cur_q  <= fit_rt;
            need_q <= req_np;
          end else begin
            st_q <= S_FAIL;
          end
        end
        S_GROW: if (pick_ok) begin
          got_q           <= got_q + NPW'(1);
          new_q[pick_idx] <= 1'b1;
          if (got_q + NPW'(1) == need_q) st_q <= S_DONE;
        end else begin
          st_q <= S_ROLL;
        end
        S_ROLL:  st_q <= S_FAIL;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '{default: UNASG};
      dead_q <= '0;
    end else begin
      for (int c = 0; c < N_CORES; c++) begin
        if (take_evt && pick_idx == CW'(c))
          own_q[c] <= {1'b0, cur_q};
        else if (roll_evt && new_q[c])
          own_q[c] <= UNASG;
        else if (rel_evt && !dead_q[c] && own_q[c] == {1'b0, rel_rt})
          own_q[c] <= UNASG;
      end
      if (flt_valid) dead_q[flt_core] <= 1'b1;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign grant     = (st_q == S_DONE);
  assign fail      = (st_q == S_FAIL);
  assign grant_rt  = cur_q;
  assign rd_owner  = own_q[rd_core];
  assign rd_failed = dead_q[rd_core];

  // R5
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || fail) |=> !busy);
  // R3
  exact_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (got_q == need_q));
  // R8
  live_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |-> (own_q[pick_idx] == UNASG && !dead_q[pick_idx]));
  // R7
  roll_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> ((new_q & ~free_mask & ~dead_q) == '0));

endmodule

// File: tb/test_mesh_bus_alloc.sv
`timescale 1ns/1ps
module test_mesh_bus_alloc;
  localparam int W = 4, H = 4, NC = 16, NR = 4, TW = 2, TH = 2, RX = 2;
  localparam int UN = 7;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rel_valid = 0, flt_valid = 0;
  logic [4:0] req_np = '0;
  logic [1:0] rel_rt = '0;
  logic [3:0] flt_core = '0, rd_core = '0;
  logic busy, grant, fail, rd_failed;
  logic [1:0] grant_rt;
  logic [2:0] rd_owner;

  always #2 clk = ~clk;

  mesh_bus_alloc i_mesh_bus_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_np(req_np),
    .busy(busy), .grant(grant), .fail(fail), .grant_rt(grant_rt),
    .rel_valid(rel_valid), .rel_rt(rel_rt), .flt_valid(flt_valid),
    .flt_core(flt_core), .rd_core(rd_core), .rd_owner(rd_owner),
    .rd_failed(rd_failed));

  int n_chk = 0, n_fail = 0;
  int m_own[NC];
  bit m_dead[NC];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int prio(int c);
    int x = c % W, y = c / W;
    int d = (x < W - 1 - x) ? x : W - 1 - x;
    int e = (y < H - 1 - y) ? y : H - 1 - y;
    return W - ((d < e) ? d : e);
  endfunction
  function automatic int tile(int c);
    return (c / W / TH) * RX + (c % W) / TW;
  endfunction
  function automatic int att(int r);
    return (r / RX) * TH * W + (r % RX) * TW;
  endfunction
  function automatic bit mfree(int c);
    return m_own[c] == -1 && !m_dead[c];
  endfunction
  function automatic bit adj(int a, int b);
    int dx = a % W - b % W, dy = a / W - b / W;
    return (dx * dx + dy * dy) == 1;
  endfunction

  // reference allocation: priority queue flood
  task automatic model_alloc(input int np, output bit ok, output int rt, output int lat);
    int cnt[NR];
    int q[$];
    int took[$];
    rt = -1;
    for (int r = 0; r < NR; r++) begin
      cnt[r] = 0;
      for (int c = 0; c < NC; c++) if (mfree(c) && tile(c) == r) cnt[r]++;
    end
    if (np > 0)
      for (int r = 0; r < NR; r++)
        if (cnt[r] >= np && (rt < 0 || cnt[r] < cnt[rt])) rt = r;
    if (rt < 0) begin ok = 0; lat = 1; return; end
    for (int c = 0; c < NC; c++) begin
      bit seed = (c == att(rt));
      for (int n = 0; n < NC; n++)
        if (adj(c, n) && m_own[n] == rt && !m_dead[n]) seed = 1;
      if (mfree(c) && tile(c) == rt && seed) q.push_back(c);
    end
    while (took.size() < np && q.size() > 0) begin
      int bi = 0, c;
      for (int i = 1; i < q.size(); i++)
        if (prio(q[i]) > prio(q[bi]) || (prio(q[i]) == prio(q[bi]) && q[i] < q[bi])) bi = i;
      c = q[bi];
      q.delete(bi);
      m_own[c] = rt;
      took.push_back(c);
      for (int n = 0; n < NC; n++) begin
        bit inq = 0;
        foreach (q[i]) if (q[i] == n) inq = 1;
        if (adj(c, n) && tile(n) == rt && mfree(n) && !inq) q.push_back(n);
      end
    end
    if (took.size() == np) begin
      ok = 1; lat = np + 1;
    end else begin
      foreach (took[i]) m_own[took[i]] = -1;
      ok = 0; lat = took.size() + 3;
    end
  endtask

  task automatic sweep(input string tag);
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      rd_core = 4'(c);
      #1;
      chk({tag, " R4 owner"}, int'(rd_owner), (m_own[c] == -1) ? UN : m_own[c]);
      chk({tag, " R8 dead flag"}, int'(rd_failed), int'(m_dead[c]));
    end
  endtask

  task automatic run_req(input int np, input string tag, input bit poke);
    bit ok; int rt, lat;
    @(negedge clk);
    req_valid = 1; req_np = 5'(np);
    model_alloc(np, ok, rt, lat);
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      req_valid = 0;
      rel_valid = 0;
      if (poke && i == 1) begin
        req_valid = 1; req_np = 5'd1;
        rel_valid = 1; rel_rt = 2'd1;
      end
      chk({tag, " R5 busy"}, int'(busy), 1);
      chk({tag, " grant pulse"}, int'(grant), int'(ok && i == lat));
      chk({tag, " fail pulse"}, int'(fail), int'(!ok && i == lat));
      if (ok && i == lat) chk({tag, " R2 router"}, int'(grant_rt), rt);
    end
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
    chk({tag, " R5 idle after"}, int'(busy), 0);
    sweep(tag);
  endtask

  task automatic do_rel(input int r);
    @(negedge clk);
    rel_valid = 1; rel_rt = 2'(r);
    @(negedge clk);
    rel_valid = 0;
    for (int c = 0; c < NC; c++) if (m_own[c] == r && !m_dead[c]) m_own[c] = -1;
    sweep("R9 release");
  endtask

  task automatic do_flt(input int c);
    @(negedge clk);
    flt_valid = 1; flt_core = 4'(c);
    @(negedge clk);
    flt_valid = 0;
    m_dead[c] = 1;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin m_own[c] = -1; m_dead[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R5 reset busy", int'(busy), 0);
    chk("R5 reset grant", int'(grant), 0);
    chk("R5 reset fail", int'(fail), 0);
    sweep("reset");
    run_req(3, "R3 first bus", 0);      // r0 takes 0,1,4
    run_req(2, "R2 tie low", 0);        // r1 takes 2,3
    run_req(1, "R2 fewest", 0);         // r0 grows through owned core: 5
    run_req(5, "R6 too big", 0);
    run_req(0, "R6 zero", 0);
    do_rel(1);
    do_flt(11);
    do_flt(14);
    run_req(2, "R7 partial stall", 0);  // r3 takes 10 then stalls
    run_req(3, "R1 priority", 0);       // r1 picks 2,3,7 not 6
    do_flt(0);
    do_rel(0);                          // dead core 0 keeps owner 0
    run_req(3, "R8 dead blocks", 0);    // r0 cut off, stall at k=0
    run_req(1, "R3 via owned", 0);      // r1 takes 6
    run_req(1, "R9 busy ignores", 1);   // release r1 and new req ignored
    do_rel(3);
    do_rel(2);
    run_req(4, "R1 full tile", 0);      // r2 takes whole tile
    summary();
  end

endmodule